// File: doc/BRIEF.md
# Bit-Band Alias Write Bridge

This bridge sits between a single CPU bus master and a word-addressed target such as a block of GPIO and peripheral registers. Part of the CPU address map is an alias window in which every 32-bit word stands for exactly one bit of a smaller target region. Software sets or clears one target bit with one plain store to its alias word. It reads one bit with one plain load, which returns that bit alone in bit 0. The bridge does the bit work on the target side, so the core never has to run a load, mask and store sequence itself.

Alias stores are posted into a small write buffer and the core moves on at once. The bridge then drains the buffer in order. An ordinary target word is updated by a read of the whole word, a one-bit change and a write-back. The target bus stays locked to that sequence until the write-back completes. A target word in the set/clear window has companion set and clear registers, and the bridge writes a one-hot mask into one of them without reading anything. Alias loads and accesses outside the alias window wait until the buffer is empty, so they always see every earlier alias store. Accesses outside the window then go to the target unchanged.

Top module: `bitband_bridge`

## Requirements
- R1: Out of reset, and while no CPU request is present and no buffered write is pending, tgt_req and cpu_ready are low.
- R2: A store to alias address ALIAS_BASE + (byte_offset << 5) + (bit << 2) with data bit 0 equal to 1 sets bit `bit` of the ordinary target word at TGT_BASE + byte_offset. All other bits of that word keep their values.
- R3: A store whose data bit 0 is 0 clears the addressed bit. Data bits 31:1 have no effect.
- R4: An ordinary-target update appears on the target bus as a read of the word, followed directly by a write of the same address. No other target access comes between the two.
- R5: A target word whose offset lies in [SC_LO, SC_HI) is a set/clear word. An alias store of 1 writes the one-hot mask of the bit to word + 4, and a store of 0 writes it to word + 8. No target read is made for it.
- R6: An alias store is accepted in the cycle it is presented (cpu_ready high) while fewer than 4 stores are buffered. With 4 buffered it stalls (cpu_ready low) until an entry retires.
- R7: An alias load returns the addressed target bit in bit 0 and zeros in bits 31:1. For a set/clear word the bit is read from the data word itself. The load completes only after all earlier buffered stores have reached the target.
- R8: A load or store outside the alias window reaches the target with its address and write data unchanged, and a load returns the target word unchanged. It also waits until the buffer has drained.
- R9: Buffered stores reach the target in the order they were accepted, so the last of several stores to one bit decides its final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | CPU access is a store |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU store data |
| cpu_ready | output | 1 | Access accepted (store) or completed with data (load) |
| cpu_rdata | output | 32 | Load data, valid while cpu_ready is high for a load |
| tgt_req | output | 1 | Target access request, held until tgt_ack |
| tgt_we | output | 1 | Target access is a write |
| tgt_addr | output | 32 | Target byte address |
| tgt_wdata | output | 32 | Target write data |
| tgt_ack | input | 1 | Target completes the current access |
| tgt_rdata | input | 32 | Target read data, valid with tgt_ack |

## Verification
The bench goes after stores whose upper data bits disagree with bit 0. A bridge that tested the whole word would set bits that should be cleared. It logs every target access to confirm that each ordinary update is a read directly followed by a write-back to the same address. A leaky lock would let another access slip into that gap, and a set/clear bridge that still read first would show an extra read. A slow target fills the buffer so that the fifth back-to-back store must stall. A set-then-clear pair to the same bit, with an alias load right behind it, shows whether a design reorders the buffer or lets loads overtake pending stores.

// File: rtl/bb_pkg.sv
package bb_pkg;
    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_WB   = 1'b1
    } eng_state_e;
endpackage

// File: rtl/bb_decode.sv
module bb_decode #(
    parameter int                  ADDR_W     = 32,
    parameter int                  DATA_W     = 32,
    parameter int                  TGT_BITS   = 20,
    parameter logic [ADDR_W-1:0]   ALIAS_BASE = 32'h2200_0000,
    parameter logic [ADDR_W-1:0]   TGT_BASE   = 32'h2000_0000,
    parameter logic [TGT_BITS-1:0] SC_LO      = 20'h8_0000,
    parameter logic [TGT_BITS-1:0] SC_HI      = 20'h8_0040,
    localparam int                 BIT_W      = $clog2(DATA_W)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_alias,
    output logic [ADDR_W-1:0] word_addr,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              is_sc
);
    localparam int BYTE_W     = $clog2(DATA_W / 8);
    localparam int ALIAS_BITS = TGT_BITS + 3 + BYTE_W;
    localparam int SHIFT      = BYTE_W + BIT_W;

    logic [TGT_BITS-1:0] tgt_ofs;
    logic                unused_low;

    assign unused_low = ^addr[BYTE_W-1:0];

    always_comb begin
        is_alias  = (addr[ADDR_W-1:ALIAS_BITS] == ALIAS_BASE[ADDR_W-1:ALIAS_BITS]);
        bit_idx   = addr[BYTE_W +: BIT_W];
        tgt_ofs   = {addr[ALIAS_BITS-1:SHIFT], {BYTE_W{1'b0}}};
        word_addr = TGT_BASE;
        word_addr[TGT_BITS-1:0] = tgt_ofs;
        is_sc     = (tgt_ofs >= SC_LO) && (tgt_ofs < SC_HI);
    end
endmodule

// File: rtl/bb_fifo.sv
module bb_fifo #(
    parameter int WIDTH = 40,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign head  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign count = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bb_engine.sv
module bb_engine
    import bb_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] SC_SET_OFS = 32'h4,
    parameter logic [ADDR_W-1:0] SC_CLR_OFS = 32'h8,
    localparam int               BIT_W      = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [ADDR_W-1:0] head_word,
    input  logic [BIT_W-1:0]  head_bit,
    input  logic              head_val,
    input  logic              head_sc,
    output logic              pop,
    output logic              busy_wb,
    output logic              eng_req,
    output logic              eng_we,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic              tgt_ack,
    input  logic [DATA_W-1:0] tgt_rdata
);
    typedef struct packed {
        eng_state_e        state;
        logic [DATA_W-1:0] wb;
    } eng_t;

    eng_t st_d, st_q;
    logic [DATA_W-1:0] mask;

    assign mask    = {{(DATA_W-1){1'b0}}, 1'b1} << head_bit;
    assign busy_wb = (st_q.state == ENG_WB);

    always_comb begin
        st_d      = st_q;
        pop       = 1'b0;
        eng_req   = 1'b0;
        eng_we    = 1'b0;
        eng_addr  = head_word;
        eng_wdata = '0;
        case (st_q.state)
            ENG_IDLE: begin
                if (valid) begin
                    eng_req = 1'b1;
                    if (head_sc) begin
                        eng_we    = 1'b1;
                        eng_addr  = head_word + (head_val ? SC_SET_OFS : SC_CLR_OFS);
                        eng_wdata = mask;
                        pop       = tgt_ack;
                    end else if (tgt_ack) begin
                        st_d.wb    = head_val ? (tgt_rdata | mask) : (tgt_rdata & ~mask);
                        st_d.state = ENG_WB;
                    end
                end
            end
            ENG_WB: begin
                eng_req   = 1'b1;
                eng_we    = 1'b1;
                eng_wdata = st_q.wb;
                if (tgt_ack) begin
                    pop        = 1'b1;
                    st_d.state = ENG_IDLE;
                end
            end
            default: st_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ENG_IDLE, wb: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
    parameter int                  ADDR_W     = 32,
    parameter int                  DATA_W     = 32,
    parameter int                  TGT_BITS   = 20,
    parameter int                  FIFO_DEPTH = 4,
    parameter logic [ADDR_W-1:0]   ALIAS_BASE = 32'h2200_0000,
    parameter logic [ADDR_W-1:0]   TGT_BASE   = 32'h2000_0000,
    parameter logic [TGT_BITS-1:0] SC_LO      = 20'h8_0000,
    parameter logic [TGT_BITS-1:0] SC_HI      = 20'h8_0040,
    parameter logic [ADDR_W-1:0]   SC_SET_OFS = 32'h4,
    parameter logic [ADDR_W-1:0]   SC_CLR_OFS = 32'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              tgt_req,
    output logic              tgt_we,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              tgt_ack,
    input  logic [DATA_W-1:0] tgt_rdata
);
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int ENTRY_W = ADDR_W + BIT_W + 2;
    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

    logic              cpu_is_alias, cpu_is_sc, posted;
    logic [ADDR_W-1:0] cpu_word;
    logic [BIT_W-1:0]  cpu_bit;
    logic [ENTRY_W-1:0] push_entry, head_entry;
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [CNT_W-1:0]  fifo_count;
    logic [ADDR_W-1:0] head_word;
    logic [BIT_W-1:0]  head_bit;
    logic              head_val, head_sc, eng_busy;
    logic              eng_req, eng_we;
    logic [ADDR_W-1:0] eng_addr;
    logic [DATA_W-1:0] eng_wdata;

    bb_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TGT_BITS(TGT_BITS),
        .ALIAS_BASE(ALIAS_BASE), .TGT_BASE(TGT_BASE),
        .SC_LO(SC_LO), .SC_HI(SC_HI)
    ) u_dec (
        .addr(cpu_addr), .is_alias(cpu_is_alias), .word_addr(cpu_word),
        .bit_idx(cpu_bit), .is_sc(cpu_is_sc)
    );

    assign posted     = cpu_we && cpu_is_alias;
    assign fifo_push  = cpu_req && posted && !fifo_full;
    assign push_entry = {cpu_word, cpu_bit, cpu_wdata[0], cpu_is_sc};
    assign {head_word, head_bit, head_val, head_sc} = head_entry;

    bb_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(push_entry),
        .pop(fifo_pop), .head(head_entry), .empty(fifo_empty),
        .full(fifo_full), .count(fifo_count)
    );

    bb_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SC_SET_OFS(SC_SET_OFS), .SC_CLR_OFS(SC_CLR_OFS)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .valid(!fifo_empty),
        .head_word(head_word), .head_bit(head_bit), .head_val(head_val),
        .head_sc(head_sc), .pop(fifo_pop), .busy_wb(eng_busy),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
    );

    always_comb begin
        if (!fifo_empty) begin
            tgt_req   = eng_req;
            tgt_we    = eng_we;
            tgt_addr  = eng_addr;
            tgt_wdata = eng_wdata;
        end else begin
            tgt_req   = cpu_req && !posted;
            tgt_we    = cpu_we;
            tgt_addr  = cpu_is_alias ? cpu_word : cpu_addr;
            tgt_wdata = cpu_wdata;
        end
        if (posted) cpu_ready = cpu_req && !fifo_full;
        else        cpu_ready = cpu_req && fifo_empty && tgt_ack;
        if (cpu_is_alias) cpu_rdata = {{(DATA_W-1){1'b0}}, tgt_rdata[cpu_bit]};
        else              cpu_rdata = tgt_rdata;
    end
endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              is_alias,
    input logic              tgt_req,
    input logic              tgt_we,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic              tgt_ack,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              head_sc,
    input logic              eng_busy
);
    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req && fifo_count == '0) |-> (!tgt_req && !cpu_ready));

    assert_rmw_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_we && tgt_ack && fifo_count != '0) |=> (tgt_req && tgt_we && $stable(tgt_addr)));

    assert_rmw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !tgt_ack) |=> (eng_busy && tgt_req && tgt_we && $stable(tgt_addr)));

    assert_sc_noread_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_we && fifo_count != '0) |-> !head_sc);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && is_alias && fifo_count == CNT_W'(DEPTH)) |-> !cpu_ready);

    assert_alias_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && is_alias && cpu_ready) |-> (cpu_rdata[DATA_W-1:1] == '0));

    assert_drain_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !(cpu_we && is_alias)) |-> (fifo_count == '0));
endmodule

bind bitband_bridge bb_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .is_alias(cpu_is_alias),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_ack(tgt_ack),
    .fifo_count(fifo_count), .head_sc(head_sc), .eng_busy(eng_busy)
);

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;
    localparam logic [31:0] ALIAS_BASE = 32'h2200_0000;
    localparam logic [31:0] TGT_BASE   = 32'h2000_0000;
    localparam logic [31:0] SC_LO      = 32'h0008_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        tgt_req, tgt_we, tgt_ack;
    logic [31:0] tgt_addr, tgt_wdata, tgt_rdata;

    int checks = 0;
    int fails  = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    int cycles = 0;

    logic [31:0] ord_mem [64];
    logic [31:0] sc_mem  [4];
    logic        log_we   [256];
    logic [31:0] log_addr [256];
    logic [31:0] log_data [256];
    int          log_n = 0;

    always #2 clk = ~clk;

    bitband_bridge dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .tgt_req(tgt_req), .tgt_we(tgt_we),
        .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack),
        .tgt_rdata(tgt_rdata)
    );

    function automatic logic [31:0] model_rd(input logic [31:0] a);
        logic [31:0] off;
        off = a - TGT_BASE;
        if (off < 32'd256) return ord_mem[off[7:2]];
        if (off >= SC_LO && off < SC_LO + 32'd64 && off[3:2] == 2'd0) return sc_mem[off[5:4]];
        return 32'h0;
    endfunction

    assign tgt_ack   = tgt_req && (wcnt >= wait_cfg);
    assign tgt_rdata = model_rd(tgt_addr);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (tgt_req && !tgt_ack) wcnt <= wcnt + 1;
        else                     wcnt <= 0;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) ord_mem[i] <= '0;
            for (int i = 0; i < 4; i++)  sc_mem[i]  <= '0;
        end else if (tgt_req && tgt_ack) begin
            if (log_n < 256) begin
                log_we[log_n]   <= tgt_we;
                log_addr[log_n] <= tgt_addr;
                log_data[log_n] <= tgt_we ? tgt_wdata : 32'h0;
                log_n           <= log_n + 1;
            end
            if (tgt_we) begin
                logic [31:0] off;
                off = tgt_addr - TGT_BASE;
                if (off < 32'd256) ord_mem[off[7:2]] <= tgt_wdata;
                else if (off >= SC_LO && off < SC_LO + 32'd64) begin
                    case (off[3:2])
                        2'd0: sc_mem[off[5:4]] <= tgt_wdata;
                        2'd1: sc_mem[off[5:4]] <= sc_mem[off[5:4]] | tgt_wdata;
                        2'd2: sc_mem[off[5:4]] <= sc_mem[off[5:4]] & ~tgt_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                              output logic [31:0] rd, output int waits);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        waits = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    function automatic logic [31:0] alias_of(input logic [31:0] byte_off, input int b);
        return ALIAS_BASE + (byte_off << 5) + (b << 2);
    endfunction

    task automatic t_reset();
        @(negedge clk); #1;
        check(tgt_req == 1'b0, "R1 tgt_req idle", {31'b0, tgt_req}, 32'h0);
        check(cpu_ready == 1'b0, "R1 cpu_ready idle", {31'b0, cpu_ready}, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] rd; int w;
        cpu_access(1'b1, TGT_BASE + 32'h14, 32'h0000_F000, rd, w);
        cpu_access(1'b1, alias_of(32'h14, 12), 32'hFFFF_FFFE, rd, w);
        cpu_access(1'b1, alias_of(32'h14, 3), 32'h0000_0001, rd, w);
        cpu_access(1'b0, TGT_BASE + 32'h14, 32'h0, rd, w);
        check(rd == 32'h0000_E008, "R2 R3 bit set and clear, bit0 only", rd, 32'h0000_E008);
        cpu_access(1'b0, alias_of(32'h14, 3), 32'h0, rd, w);
        check(rd == 32'h1, "R7 alias read of set bit", rd, 32'h1);
        cpu_access(1'b0, alias_of(32'h14, 12), 32'h0, rd, w);
        check(rd == 32'h0, "R7 alias read of clear bit", rd, 32'h0);
    endtask

    task automatic t_passthrough();
        logic [31:0] rd; int w; int s;
        s = log_n;
        cpu_access(1'b1, TGT_BASE + 32'h20, 32'hA5A5_0F0F, rd, w);
        cpu_access(1'b0, TGT_BASE + 32'h20, 32'h0, rd, w);
        check(rd == 32'hA5A5_0F0F, "R8 pass-through data", rd, 32'hA5A5_0F0F);
        check(log_addr[s] == TGT_BASE + 32'h20 && log_data[s] == 32'hA5A5_0F0F,
              "R8 pass-through address unchanged", log_addr[s], TGT_BASE + 32'h20);
    endtask

    task automatic t_rmw_seq();
        logic [31:0] rd; int w; int s;
        wait_cfg = 2;
        s = log_n;
        cpu_access(1'b1, alias_of(32'h30, 7), 32'h1, rd, w);
        cpu_access(1'b0, TGT_BASE + 32'h30, 32'h0, rd, w);
        check(!log_we[s] && log_addr[s] == TGT_BASE + 32'h30, "R4 first access is read of word",
              log_addr[s], TGT_BASE + 32'h30);
        check(log_we[s+1] && log_addr[s+1] == TGT_BASE + 32'h30 && log_data[s+1] == 32'h80,
              "R4 next access is write-back", log_data[s+1], 32'h80);
        check(log_n == s + 3, "R4 no extra target access", log_n - s, 32'd3);
        wait_cfg = 0;
    endtask

    task automatic t_setclr();
        logic [31:0] rd; int w; int s;
        logic [31:0] a;
        a = TGT_BASE + SC_LO;
        cpu_access(1'b1, a, 32'h00FF_0000, rd, w);
        s = log_n;
        cpu_access(1'b1, alias_of(SC_LO, 2), 32'h1, rd, w);
        cpu_access(1'b1, alias_of(SC_LO, 16), 32'hFFFF_FFFE, rd, w);
        cpu_access(1'b0, alias_of(SC_LO, 2), 32'h0, rd, w);
        check(rd == 32'h1, "R7 set/clear word alias read", rd, 32'h1);
        check(log_we[s] && log_addr[s] == a + 32'h4 && log_data[s] == 32'h4,
              "R5 set register mask", log_data[s], 32'h4);
        check(log_we[s+1] && log_addr[s+1] == a + 32'h8 && log_data[s+1] == 32'h0001_0000,
              "R5 clear register mask", log_data[s+1], 32'h0001_0000);
        check(!log_we[s+2] && log_addr[s+2] == a && log_n == s + 3,
              "R5 no read before mask writes", log_n - s, 32'd3);
        cpu_access(1'b0, a, 32'h0, rd, w);
        check(rd == 32'h00FE_0004, "R5 set/clear word value", rd, 32'h00FE_0004);
    endtask

    task automatic t_posted();
        logic [31:0] rd; int w [5];
        wait_cfg = 4;
        cpu_access(1'b1, alias_of(32'h40, 0), 32'h1, rd, w[0]);
        cpu_access(1'b1, alias_of(32'h40, 1), 32'h1, rd, w[1]);
        cpu_access(1'b1, alias_of(32'h40, 2), 32'h1, rd, w[2]);
        cpu_access(1'b1, alias_of(32'h40, 3), 32'h1, rd, w[3]);
        cpu_access(1'b1, alias_of(32'h40, 0), 32'h0, rd, w[4]);
        check(w[0] + w[1] + w[2] + w[3] == 0, "R6 four stores accepted without stall",
              w[0] + w[1] + w[2] + w[3], 32'd0);
        check(w[4] > 0, "R6 fifth store stalls on full buffer", w[4], 32'd1);
        cpu_access(1'b0, alias_of(32'h40, 0), 32'h0, rd, w[0]);
        check(rd == 32'h0, "R7 R9 alias read after pending stores", rd, 32'h0);
        cpu_access(1'b0, TGT_BASE + 32'h40, 32'h0, rd, w[0]);
        check(rd == 32'h0000_000E, "R9 in-order result", rd, 32'h0000_000E);
        wait_cfg = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        #1 rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_passthrough();
        t_rmw_seq();
        t_setclr();
        t_posted();
        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule